// File: doc/BRIEF.md
# Card Clock Divider with Bypass

This block derives the clock sent to an SD or MMC card from a faster master clock. Software-side logic presents a requested divider value. The block turns it into an effective field N and produces a card clock of master/(2N) with equal high and low times. A field of zero passes the master clock straight through, unless double data rate is on. In that mode a pass-through clock is not allowed and the block divides by two instead. Requests larger than the field can hold are clamped to the field's all-ones value.

Next to the clock, the block decodes the card timing mode into two outputs. The first is a bus-speed flag for the faster single-data-rate modes. The second picks the receive sampling clock, and it is forced to the feedback path in the fastest single-data-rate mode. The effective divide ratio in use is reported as a status value. A changed request takes effect only where the card clock falls, so the card never sees a shortened pulse.

Top module: `sdclk_div`

## Requirements
- R1: For an effective field N of 1 or more, the card clock period is 2N master cycles, and `ratio_o` reads 2N once the setting is active.
- R2: In divide mode the card clock is high for exactly N master cycles and low for exactly N master cycles.
- R3: A request of 0 with `ddr_en_i` low selects bypass: `card_clk_o` follows `clk_i`, and `ratio_o` reads 1.
- R4: With `ddr_en_i` high, a request of 0 acts as a field of 1 (ratio 2), so bypass never occurs. Non-zero requests are unchanged by `ddr_en_i`.
- R5: `div_req_i` is 12 bits wide. A request above 1023 is clamped to a field of 1023, giving a ratio of 2046.
- R6: A new field is taken only at a falling edge of the divided card clock. A high phase that has started completes with the old length, and `ratio_o` changes at that falling edge.
- R7: `speed_i` encodes 0 legacy, 1 high speed, 2 SDR12, 3 SDR25, 4 SDR50, 5 SDR104, 6 DDR50, 7 reserved. `bus_speed_o` is 1 exactly for codes 4 and above.
- R8: `rx_sel_o` encodes 0 internal clock, 1 returned card clock, 2 feedback clock. It is 2 whenever `speed_i` is 5. Otherwise it equals `rx_src_i`, and a `rx_src_i` of 3 maps to 0.
- R9: While reset is asserted, `card_clk_o` is 0 and `ratio_o` reads 2 (field 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_req_i | input | 12 | Requested divider field |
| ddr_en_i | input | 1 | Double data rate enable (forbids bypass) |
| speed_i | input | 3 | Card timing mode code |
| rx_src_i | input | 2 | Requested receive sampling clock source |
| card_clk_o | output | 1 | Clock to the card |
| rx_sel_o | output | 2 | Effective receive sampling clock select |
| bus_speed_o | output | 1 | High bus speed flag |
| ratio_o | output | 11 | Effective master-to-card divide ratio in use |

## Verification
The hardest case to reach is a request that changes while the card clock is already high. The old high phase must run to its full length, and the new ratio must appear only at the following fall. The stimulus first runs a known ratio and waits for a card-clock rising edge, seen on a sample taken away from the master edge. In that same sample it writes a smaller request, then counts the high samples and watches when `ratio_o` moves. The saturated case is reached from a bypass setting with an over-range request, and the run measures one full 2046-cycle period.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  typedef enum logic [2:0] {
    SPD_LEGACY = 3'd0,
    SPD_HS     = 3'd1,
    SPD_SDR12  = 3'd2,
    SPD_SDR25  = 3'd3,
    SPD_SDR50  = 3'd4,
    SPD_SDR104 = 3'd5,
    SPD_DDR50  = 3'd6,
    SPD_RSV    = 3'd7
  } speed_e;

  typedef enum logic [1:0] {
    RX_INT = 2'd0,
    RX_RET = 2'd1,
    RX_FB  = 2'd2,
    RX_RSV = 2'd3
  } rx_src_e;

endpackage

// File: rtl/sdclk_field.sv
module sdclk_field #(
  parameter int FIELD_W = 10,
  parameter int REQ_W   = 12
) (
  input  logic [REQ_W-1:0]   req_i,
  input  logic               ddr_en_i,
  output logic [FIELD_W-1:0] field_o
);
  localparam logic [REQ_W-1:0]   MAX_REQ = REQ_W'({FIELD_W{1'b1}});
  localparam logic [FIELD_W-1:0] MAX_FLD = {FIELD_W{1'b1}};

  logic [FIELD_W-1:0] clamped;

  always_comb begin
    clamped = (req_i > MAX_REQ) ? MAX_FLD : req_i[FIELD_W-1:0];
    // bypass is not allowed with double data rate
    if (ddr_en_i && clamped == '0) field_o = FIELD_W'(1);
    else                           field_o = clamped;
  end
endmodule

// File: rtl/sdclk_rxsel.sv
module sdclk_rxsel
  import sdclk_pkg::*;
(
  input  logic [2:0] speed_i,
  input  logic [1:0] rx_src_i,
  output logic [1:0] rx_sel_o,
  output logic       bus_speed_o
);
  always_comb begin
    bus_speed_o = (speed_i >= SPD_SDR50);
    if (speed_i == SPD_SDR104)    rx_sel_o = RX_FB;
    else if (rx_src_i == RX_RSV)  rx_sel_o = RX_INT;
    else                          rx_sel_o = rx_src_i;
  end
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen #(
  parameter int FIELD_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FIELD_W-1:0] next_field_i,
  output logic               div_clk_o,
  output logic               bypass_o,
  output logic [FIELD_W-1:0] act_field_o
);
  logic [FIELD_W-1:0] act_q, cnt_q;
  logic               div_q;
  logic               byp, term;

  assign byp  = (act_q == '0);
  assign term = (cnt_q == act_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= FIELD_W'(1);
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (byp) begin
      act_q <= next_field_i;
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      div_q <= ~div_q;
      if (div_q) act_q <= next_field_i;  // reload only on the falling toggle
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign div_clk_o   = div_q;
  assign bypass_o    = byp;
  assign act_field_o = act_q;

  assert_cnt_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byp |-> (cnt_q < act_q));

  assert_half_period_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byp && !term) |=> $stable(div_q));

  assert_apply_falling_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byp && !(term && div_q)) |=> $stable(act_q));

  assert_reload_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byp && term && div_q) |=> !div_q);
endmodule

// File: rtl/sdclk_div.sv
module sdclk_div
  import sdclk_pkg::*;
#(
  parameter int FIELD_W = 10,
  parameter int REQ_W   = 12,
  localparam int RATIO_W = FIELD_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [REQ_W-1:0]   div_req_i,
  input  logic               ddr_en_i,
  input  logic [2:0]         speed_i,
  input  logic [1:0]         rx_src_i,
  output logic               card_clk_o,
  output logic [1:0]         rx_sel_o,
  output logic               bus_speed_o,
  output logic [RATIO_W-1:0] ratio_o
);
  localparam logic [REQ_W-1:0]   MAX_REQ = REQ_W'({FIELD_W{1'b1}});
  localparam logic [FIELD_W-1:0] MAX_FLD = {FIELD_W{1'b1}};

  logic [FIELD_W-1:0] eff_field, act_field;
  logic               div_clk, bypass;

  sdclk_field #(.FIELD_W(FIELD_W), .REQ_W(REQ_W)) u_field (
    .req_i    (div_req_i),
    .ddr_en_i (ddr_en_i),
    .field_o  (eff_field)
  );

  sdclk_gen #(.FIELD_W(FIELD_W)) u_gen (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .next_field_i (eff_field),
    .div_clk_o    (div_clk),
    .bypass_o     (bypass),
    .act_field_o  (act_field)
  );

  sdclk_rxsel u_rxsel (
    .speed_i     (speed_i),
    .rx_src_i    (rx_src_i),
    .rx_sel_o    (rx_sel_o),
    .bus_speed_o (bus_speed_o)
  );

  // bypass hands the master clock to the card unchanged
  assign card_clk_o = bypass ? clk_i : div_clk;
  assign ratio_o    = bypass ? RATIO_W'(1) : {act_field, 1'b0};

  assert_bypass_ratio_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_req_i == '0 && !ddr_en_i) |-> (eff_field == '0));

  assert_ddr_no_bypass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ddr_en_i && $past(ddr_en_i)) |-> (ratio_o != RATIO_W'(1)));

  assert_saturate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_req_i > MAX_REQ) |-> (eff_field == MAX_FLD));

  assert_bus_speed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (speed_i == SPD_LEGACY || speed_i == SPD_SDR104) |-> (bus_speed_o == (speed_i == SPD_SDR104)));

  assert_fb_sel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (speed_i == SPD_SDR104) |-> (rx_sel_o == RX_FB));
endmodule

// File: tb/tb_sdclk_div.sv
module tb_sdclk_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] div_req = 12'd3;
  logic        ddr_en = 1'b0;
  logic [2:0]  speed = 3'd0;
  logic [1:0]  rx_src = 2'd0;
  logic        card_clk;
  logic [1:0]  rx_sel;
  logic        bus_speed;
  logic [10:0] ratio;

  int errors = 0, checks = 0;
  int push_cnt = 0, pop_cnt = 0;

  typedef struct { int ratio; string tag; } exp_t;
  exp_t exp_q[$];

  sdclk_div dut (
    .clk_i(clk), .rst_ni(rst_n), .div_req_i(div_req), .ddr_en_i(ddr_en),
    .speed_i(speed), .rx_src_i(rx_src), .card_clk_o(card_clk),
    .rx_sel_o(rx_sel), .bus_speed_o(bus_speed), .ratio_o(ratio)
  );

  always #5 clk = ~clk;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // driver: apply a request and push the expected ratio
  task automatic drive_div(int d, bit dd, int exp_ratio, string tag);
    exp_t e;
    @(negedge clk);
    div_req = 12'(d);
    ddr_en  = dd;
    e.ratio = exp_ratio;
    e.tag   = tag;
    exp_q.push_back(e);
    push_cnt++;
    wait (pop_cnt == push_cnt);
  endtask

  task automatic check_mode(int sp, int src, int exp_rx, bit exp_bus);
    @(negedge clk);
    speed  = 3'(sp);
    rx_src = 2'(src);
    #1;
    chk(rx_sel == 2'(exp_rx), "R8 rx_sel", rx_sel, exp_rx);
    chk(bus_speed == exp_bus, "R7 bus_speed", bus_speed, exp_bus);
  endtask

  // monitor: pop the expected item and measure the card clock
  initial begin
    forever begin
      exp_t e;
      int   n;
      bit   prev;
      int   hi, lo;
      wait (push_cnt != pop_cnt);
      e = exp_q.pop_front();
      n = 0;
      @(negedge clk);
      while (int'(ratio) != e.ratio && n < 6000) begin
        @(negedge clk);
        n++;
      end
      chk(int'(ratio) == e.ratio, {e.tag, " ratio"}, ratio, e.ratio);
      if (e.ratio == 1) begin
        for (int i = 0; i < 4; i++) begin
          @(posedge clk); #1;
          chk(card_clk == 1'b1, "R3 bypass high", card_clk, 1);
          @(negedge clk); #1;
          chk(card_clk == 1'b0, "R3 bypass low", card_clk, 0);
        end
      end else begin
        prev = card_clk;
        n = 0;
        @(negedge clk);
        while (!(prev == 1'b0 && card_clk == 1'b1) && n < 6000) begin
          prev = card_clk;
          @(negedge clk);
          n++;
        end
        hi = 0;
        while (card_clk == 1'b1) begin hi++; @(negedge clk); end
        lo = 0;
        while (card_clk == 1'b0) begin lo++; @(negedge clk); end
        chk(hi == e.ratio / 2, {e.tag, " R2 high time"}, hi, e.ratio / 2);
        chk(lo == e.ratio / 2, {e.tag, " R2 low time"}, lo, e.ratio / 2);
        chk(hi + lo == e.ratio, {e.tag, " R1 period"}, hi + lo, e.ratio);
      end
      pop_cnt++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    bit prev;
    int hi;
    int last_ratio;
    int n;
    repeat (3) @(negedge clk);
    chk(card_clk == 1'b0, "R9 reset card clock", card_clk, 0);
    chk(ratio == 11'd2, "R9 reset ratio", ratio, 2);
    rst_n = 1'b1;

    check_mode(0, 1, 1, 0);   // R8 pass-through, R7 legacy
    check_mode(4, 0, 0, 1);   // R7 SDR50
    check_mode(5, 1, 2, 1);   // R8 feedback forced at SDR104
    check_mode(3, 3, 0, 0);   // R8 reserved source maps to internal
    check_mode(6, 2, 2, 1);   // R7 DDR50

    drive_div(3, 0, 6, "R1");
    drive_div(1, 0, 2, "R1");
    drive_div(0, 0, 1, "R3");
    drive_div(0, 1, 2, "R4");
    drive_div(7, 1, 14, "R4");
    drive_div(0, 0, 1, "R3");
    drive_div(4000, 0, 2046, "R5");
    drive_div(5, 0, 10, "R1");

    // R6: change the request in the first high sample of a fresh card pulse
    @(negedge clk);
    prev = card_clk;
    @(negedge clk);
    while (!(prev == 1'b0 && card_clk == 1'b1)) begin
      prev = card_clk;
      @(negedge clk);
    end
    div_req = 12'd2;
    hi = 0;
    last_ratio = 0;
    while (card_clk == 1'b1) begin
      hi++;
      last_ratio = int'(ratio);
      @(negedge clk);
    end
    chk(hi == 5, "R6 old high phase kept", hi, 5);
    chk(last_ratio == 10, "R6 ratio held during high", last_ratio, 10);
    n = 0;
    while (ratio != 11'd4 && n < 50) begin @(negedge clk); n++; end
    chk(n == 0, "R6 ratio changes at falling edge", n, 0);
    drive_div(2, 0, 4, "R6");

    finish_run();
  end
endmodule